// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Overflow Flags

A free-running 32-bit time counter is driven by a slow counting clock. A programmable down-counting prescaler reloads from a software-set value. It produces one tick every reload+1 counting-clock cycles, and each tick advances the counter by one. The block reports three events: the second tick, the counter reaching its alarm point, and the counter wrapping past all ones. Each event is reported as an event-cycle indication and as a sticky flag.

All three events are aligned to the last counting-clock cycle before the counter changes. An event is visible in the cycle where the prescaler is at zero and the counter still holds its old value. The alarm event fires while the counter equals the alarm value, so the counter is about to become alarm+1. Software loads the reload value, the counter and the alarm value through a single-cycle register port. It reads them back through a combinational read port, and clears a flag by writing 0 to its bit. Writes to the counter or alarm value are meant to be made right after a second event.

Top module: `rtc_alarm_counter`

## Requirements
- R1: The prescaler counts down from the reload value to 0 and then reloads, so the counter advances once every reload+1 cycles. Writing the reload register (address 2) also loads the prescaler with the new value at that edge. The current prescaler value reads back at address 5.
- R2: The counter (address 3) changes only at the edge that ends a cycle in which the prescaler is 0. At that edge it increments by one. Otherwise it holds its value.
- R3: `sec_o` is high exactly in the cycles where the prescaler is 0. Those cycles also set the second flag, status bit 0.
- R4: `alarm_o` is high in a tick cycle whose counter equals the alarm register (address 4). It is therefore high while the counter is about to become alarm+1. That cycle sets the alarm flag, status bit 1.
- R5: A tick cycle with the counter at 0xFFFFFFFF sets the overflow flag, status bit 2. The counter is 0x00000000 after that edge.
- R6: Flags stay set until software writes the status register (address 0) with 0 in the flag's bit. A 1 in a bit leaves that flag unchanged. A status read shows each flag as set already during its event cycle.
- R7: When an event and a clear of the same flag fall in one cycle, the flag is set afterwards.
- R8: Each interrupt output is its flag (as read in the status register) ANDed with the enable bit at the same position in the enable register (address 1). Bit 0 is second, bit 1 is alarm and bit 2 is overflow.
- R9: A counter write sets the counter to the written value at the next edge, overriding any tick in that cycle. The write itself sets no flag.
- R10: Reset gives: counter 0, flags 0, enables 0, reload and prescaler equal to parameter PRE_RST (3 by default), and alarm all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | CNT_W | Read data, combinational |
| sec_o | output | 1 | High in each prescaler-zero cycle |
| alarm_o | output | 1 | High in the alarm event cycle |
| irq_sec_o | output | 1 | Second interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt |
| irq_ovf_o | output | 1 | Overflow interrupt |

## Verification
The assertions check the following on every cycle:
- the prescaler's step and reload rule, including the load on a reload write;
- that the counter holds except at a tick, and steps by one at a tick;
- that an alarm event is followed by the counter equalling alarm+1, and an overflow event by zero;
- flag stickiness, clear behaviour and set-over-clear priority.

Only the bench scenarios can show the following:
- the exact event cycles against arithmetically computed counter values, over a sweep of reload values;
- the effect of enable masks on the interrupt pins;
- that a counter write which lands on the alarm value raises no flag until the next natural tick.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned NFLAG   = 3;
  localparam int unsigned FLG_SEC = 0;
  localparam int unsigned FLG_ALM = 1;
  localparam int unsigned FLG_OVF = 2;

  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_IRQEN  = 3'd1,
    REG_RELOAD = 3'd2,
    REG_COUNT  = 3'd3,
    REG_ALARM  = 3'd4,
    REG_PRESC  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRE_W   = 20,
  parameter int unsigned PRE_RST = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PRE_W-1:0] load_val_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [PRE_W-1:0] reload_o
);
  localparam logic [PRE_W-1:0] RST_V = PRE_W'(PRE_RST);

  logic [PRE_W-1:0] pre_q, reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= RST_V;
      reload_q <= RST_V;
    end else if (load_i) begin
      pre_q    <= load_val_i;
      reload_q <= load_val_i;
    end else if (pre_q == '0) begin
      pre_q <= reload_q;
    end else begin
      pre_q <= pre_q - 1'b1;
    end
  end

  assign tick_o   = (pre_q == '0);
  assign pre_o    = pre_q;
  assign reload_o = reload_q;

  AST_PRE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_i) |=> (pre_q == $past(reload_q))); // R1
  AST_PRE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !load_i) |=> (pre_q == $past(pre_q) - 1'b1)); // R1
  AST_PRE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pre_q == $past(load_val_i) && reload_q == $past(load_val_i))); // R1
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_cnt_i,
  input  logic             wr_alm_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] alarm_o,
  output logic             alarm_hit_o,
  output logic             ovf_hit_o
);
  logic [CNT_W-1:0] cnt_q, alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_cnt_i) begin
      cnt_q <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       alarm_q <= '1;
    else if (wr_alm_i) alarm_q <= wdata_i;
  end

  // events sit in the cycle before the counter moves
  assign alarm_hit_o = tick_i && (cnt_q == alarm_q);
  assign ovf_hit_o   = tick_i && (&cnt_q);
  assign cnt_o       = cnt_q;
  assign alarm_o     = alarm_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt_i) |=> $stable(cnt_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_ALARM_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_hit_o && !wr_cnt_i) |=> (cnt_q == $past(alarm_q) + 1'b1)); // R4
  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_hit_o && !wr_cnt_i) |=> (cnt_q == '0)); // R5
  AST_CNT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> (cnt_q == $past(wdata_i))); // R9
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (evt_i[i])  flag_q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end

    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !evt_i[i]) |=> !flag_q[i]); // R6
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flag_q[i]); // R7
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_alarm_counter.sv
module rtc_alarm_counter
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned PRE_W   = 20,
  parameter int unsigned PRE_RST = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             sec_o,
  output logic             alarm_o,
  output logic             irq_sec_o,
  output logic             irq_alarm_o,
  output logic             irq_ovf_o
);
  localparam int unsigned STAT_PAD = CNT_W - NFLAG;
  localparam int unsigned PRE_PAD  = CNT_W - PRE_W;

  logic             wr_stat, wr_en, wr_rel, wr_cnt, wr_alm;
  logic             tick, alarm_hit, ovf_hit;
  logic [PRE_W-1:0] pre_val, reload_val;
  logic [CNT_W-1:0] cnt_val, alarm_val;
  logic [NFLAG-1:0] evt, clr, flag, status, irq_en_q;

  assign wr_stat = wr_en_i && (wr_addr_i == REG_STATUS);
  assign wr_en   = wr_en_i && (wr_addr_i == REG_IRQEN);
  assign wr_rel  = wr_en_i && (wr_addr_i == REG_RELOAD);
  assign wr_cnt  = wr_en_i && (wr_addr_i == REG_COUNT);
  assign wr_alm  = wr_en_i && (wr_addr_i == REG_ALARM);

  rtc_prescaler #(.PRE_W(PRE_W), .PRE_RST(PRE_RST)) i_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_rel),
    .load_val_i (wr_data_i[PRE_W-1:0]),
    .tick_o     (tick),
    .pre_o      (pre_val),
    .reload_o   (reload_val)
  );

  rtc_count_core #(.CNT_W(CNT_W)) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .wr_cnt_i    (wr_cnt),
    .wr_alm_i    (wr_alm),
    .wdata_i     (wr_data_i),
    .cnt_o       (cnt_val),
    .alarm_o     (alarm_val),
    .alarm_hit_o (alarm_hit),
    .ovf_hit_o   (ovf_hit)
  );

  always_comb begin
    evt          = '0;
    evt[FLG_SEC] = tick;
    evt[FLG_ALM] = alarm_hit;
    evt[FLG_OVF] = ovf_hit;
  end

  assign clr = {NFLAG{wr_stat}} & ~wr_data_i[NFLAG-1:0];

  rtc_flag_bank #(.N(NFLAG)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (clr),
    .flag_o (flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_en_q <= '0;
    else if (wr_en) irq_en_q <= wr_data_i[NFLAG-1:0];
  end

  // flags read as set during their own event cycle
  assign status = flag | evt;

  assign sec_o       = tick;
  assign alarm_o     = alarm_hit;
  assign irq_sec_o   = status[FLG_SEC] & irq_en_q[FLG_SEC];
  assign irq_alarm_o = status[FLG_ALM] & irq_en_q[FLG_ALM];
  assign irq_ovf_o   = status[FLG_OVF] & irq_en_q[FLG_OVF];

  always_comb begin
    unique case (rd_addr_i)
      REG_STATUS: rd_data_o = {{STAT_PAD{1'b0}}, status};
      REG_IRQEN:  rd_data_o = {{STAT_PAD{1'b0}}, irq_en_q};
      REG_RELOAD: rd_data_o = {{PRE_PAD{1'b0}}, reload_val};
      REG_COUNT:  rd_data_o = cnt_val;
      REG_ALARM:  rd_data_o = alarm_val;
      REG_PRESC:  rd_data_o = {{PRE_PAD{1'b0}}, pre_val};
      default:    rd_data_o = '0;
    endcase
  end

  AST_ALARM_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> sec_o); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_q == '0) |-> !(irq_sec_o || irq_alarm_o || irq_ovf_o)); // R8
  AST_STATUS_SHOWS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_hit |-> rd_addr_i != REG_STATUS || rd_data_o[FLG_ALM]); // R6
endmodule

// File: tb/test_rtc_alarm_counter.sv
`timescale 1ns/1ps
module test_rtc_alarm_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sec, alarm, irq_sec, irq_alarm, irq_ovf;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rtc_alarm_counter i_rtc_alarm_counter (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sec_o(sec), .alarm_o(alarm), .irq_sec_o(irq_sec),
    .irq_alarm_o(irq_alarm), .irq_ovf_o(irq_ovf)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  // called at a negedge; returns at the next negedge, after the write edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v, c0, a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(3, v); chk("R10", "count", v, 0);
    rd(0, v); chk("R10", "status", v, 0);
    rd(1, v); chk("R10", "irq enables", v, 0);
    rd(2, v); chk("R10", "reload", v, 3);
    rd(5, v); chk("R10", "prescaler", v, 3);
    rd(4, v); chk("R10", "alarm", v, 32'hFFFF_FFFF);
    chk("R10", "irq pins", {irq_sec, irq_alarm, irq_ovf}, 0);

    // R1 R2 R3 sweep of reload values
    for (int r = 0; r <= 4; r++) begin
      wr(2, r);
      rd(3, c0);
      for (int k = 0; k <= 3 * (r + 1) + 1; k++) begin
        rd(5, v); chk("R1", "prescaler", v, r - (k % (r + 1)));
        rd(3, v); chk("R2", "count", v, c0 + k / (r + 1));
        chk("R3", "sec_o", sec, (k % (r + 1)) == r);
        @(negedge clk);
      end
    end

    // R4 R8 alarm with tick every cycle, only alarm interrupt enabled
    wr(1, 32'h2);
    wr(2, 0);
    a = 32'h0000_1000;
    wr(4, a);
    wr(0, 0);
    wr(3, a - 3);
    for (int k = 0; k <= 5; k++) begin
      rd(3, v); chk("R4", "count", v, a - 3 + k);
      chk("R4", "alarm_o", alarm, k == 3);
      rd(0, v); chk("R4", "alarm flag", v[1], k >= 3);
      chk("R8", "irq_alarm", irq_alarm, k >= 3);
      chk("R8", "irq_sec masked", irq_sec, 0);
      chk("R3", "sec_o at reload 0", sec, 1);
      @(negedge clk);
    end

    // R5 overflow, R6 alarm flag stays
    wr(1, 32'h4);
    wr(4, 5);
    wr(3, 32'hFFFF_FFFD);
    for (int k = 0; k <= 4; k++) begin
      rd(3, v); chk("R5", "count wrap", v, 32'hFFFF_FFFD + k);
      rd(0, v); chk("R5", "overflow flag", v[2], k >= 2);
      chk("R6", "alarm flag sticky", v[1], 1);
      chk("R8", "irq_ovf", irq_ovf, k >= 2);
      chk("R8", "irq_alarm masked", irq_alarm, 0);
      @(negedge clk);
    end

    // R6 clears: 0 clears, 1 leaves
    wr(0, 32'h3);
    rd(0, v); chk("R6", "ovf cleared", v[2], 0); chk("R6", "alarm kept", v[1], 1);
    chk("R8", "irq_ovf after clear", irq_ovf, 0);
    wr(0, 32'h5);
    rd(0, v); chk("R6", "alarm cleared", v[1], 0); chk("R6", "ovf stays clear", v[2], 0);

    // R7 clear in the alarm event cycle
    a = 32'h0000_2000;
    wr(4, a);
    wr(0, 0);
    wr(3, a);
    chk("R4", "alarm_o on written value", alarm, 1);
    wr(0, 0);
    rd(0, v); chk("R7", "alarm flag after set+clear", v[1], 1);
    rd(3, v); chk("R7", "count", v, a + 1);

    // R9 counter write to alarm value, slow prescaler
    wr(2, 10);
    wr(0, 0);
    a = 32'h0000_3000;
    wr(4, a);
    wr(3, a);
    rd(2, v); chk("R10", "reload readback", v, 10);
    rd(4, v); chk("R10", "alarm readback", v, a);
    for (int k = 0; k <= 8; k++) begin
      rd(3, v); chk("R9", "count", v, (k == 8) ? a + 1 : a);
      chk("R9", "alarm_o", alarm, k == 7);
      rd(0, v); chk("R9", "alarm flag", v[1], k >= 7);
      chk("R9", "second flag", v[0], k >= 7);
      @(negedge clk);
    end

    done = 1'b1;
    summary();
  end
endmodule